// File: doc/BRIEF.md
# Conversion Trigger and End-of-Conversion Controller

This block decides when an analog-to-digital converter starts a conversion, which channel it samples, and when the host is told that results are ready. Four trigger modes are selected by a 2-bit mode input. Two modes start on a falling edge of an active-low start pin. The other two start on a one-cycle command strobe from the serial interface. Two of the modes walk channels 0 up to a programmed last channel. The other two convert only the programmed last channel, once per trigger.

The converter itself sits outside the block. The controller pulses `adc_start` for each sample and waits for `adc_done` with the sample word. With averaging on, it accumulates N = 4, 8, 16 or 32 samples per channel and delivers the sum shifted right by log2(N). Each channel result leaves on a valid/ready stream. `res_valid` stays high, with data and channel held, until `res_ready` is seen high at a clock edge. No further sample is started while a result waits, so a stalled consumer stalls the sequence without losing data.

The active-low flag `eoc_n` tells the host that the requested work is finished. When it falls depends on the mode. It is pulled high again by a falling edge on chip select or on the start pin.

Top module: `conv_trigger_ctrl`

## Requirements
- R1: After reset, `eoc_n` is 1, `res_valid` is 0 and `adc_start` is 0.
- R2: Mode 2'b00 (pin scan): a falling edge of `cnv_start_n` converts channels 0, 1, ... up to `last_chan`, in that order. `eoc_n` stays high until the result of `last_chan` is accepted, and falls on the following clock edge.
- R3: Mode 2'b01 (pin single): each falling edge of `cnv_start_n` produces exactly one result, for channel `last_chan`. `eoc_n` falls on the clock edge after that result is accepted.
- R4: Mode 2'b10 (command scan): a one-cycle `conv_cmd` pulse starts the same scan and `eoc_n` rule as R2. In this mode `cnv_start_n` starts nothing.
- R5: Mode 2'b11 (externally timed): each `conv_cmd` pulse produces one unaveraged result for `last_chan`, whatever `avg_en` says. `eoc_n` is high on every clock edge that follows a cycle with this mode selected.
- R6: With `avg_en`=1 in modes 00, 01 and 10, each result is the sum of N consecutive samples of its channel shifted right by log2(N), where N = 4 << `avg_sel` (`avg_sel` 0..3 gives N = 4, 8, 16, 32). With `avg_en`=0 each result is a single sample.
- R7: A falling edge on `cs_n` or on `cnv_start_n` sets `eoc_n` to 1 on the next clock edge. This takes priority over a completion in the same cycle.
- R8: A trigger that arrives while a sequence is running is ignored. Mode, `last_chan`, `avg_en` and `avg_sel` are captured at the trigger, so changes made later do not affect the running sequence.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and `res_chan` hold their values and no new `adc_start` is issued.
- R10: `adc_start` is a one-cycle pulse, one per sample. `adc_chan` holds its value until the sample's `adc_done` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Trigger mode (00 pin scan, 01 pin single, 10 command scan, 11 externally timed) |
| cnv_start_n | input | 1 | Active-low conversion-start pin |
| conv_cmd | input | 1 | One-cycle conversion command strobe from the serial interface |
| cs_n | input | 1 | Active-low chip select |
| last_chan | input | CH_W | Highest channel of a scan; the channel used in the single modes |
| avg_en | input | 1 | Enables averaging |
| avg_sel | input | 2 | Averaging depth, N = 4 << avg_sel |
| adc_done | input | 1 | One-cycle pulse from the converter, sample word valid |
| adc_data | input | DATA_W | Sample word from the converter |
| adc_start | output | 1 | One-cycle request to the converter to take a sample |
| adc_chan | output | CH_W | Channel to be sampled |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_data | output | DATA_W | Averaged or single result |
| res_chan | output | CH_W | Channel of the result |
| eoc_n | output | 1 | Active-low end-of-conversion flag |

## Verification
The assertions take for granted a converter that answers each `adc_start` with exactly one `adc_done`, later and before any further start. They also assume `conv_cmd` is used only as a single-cycle strobe. The bench's converter model answers after a fixed latency and makes up its sample words from the channel and a running sample count. The bench drives `conv_cmd` only as one-cycle pulses, and it raises `cs_n` before it lowers it again. Random holds of `res_ready` push the result stream through its back-pressure paths.

// File: rtl/conv_trig_pkg.sv
package conv_trig_pkg;

  typedef enum logic [1:0] {
    MD_PIN_SCAN   = 2'b00,
    MD_PIN_SINGLE = 2'b01,
    MD_CMD_SCAN   = 2'b10,
    MD_EXT_SINGLE = 2'b11
  } trig_mode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LAUNCH,
    S_WAIT,
    S_OUT
  } seq_state_e;

  // scanning modes walk 0..last; single modes convert only last
  function automatic logic mode_scans(trig_mode_e m);
    return (m == MD_PIN_SCAN) || (m == MD_CMD_SCAN);
  endfunction

  // modes in which the start pin (not the command) triggers
  function automatic logic mode_uses_pin(trig_mode_e m);
    return (m == MD_PIN_SCAN) || (m == MD_PIN_SINGLE);
  endfunction

endpackage

// File: rtl/ctl_trig_detect.sv
module ctl_trig_detect
  import conv_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       cnv_start_n,
  input  logic       cs_n,
  input  logic       conv_cmd,
  output logic       trig,
  output logic       start_fall,
  output logic       cs_fall
);

  logic start_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b1;
      cs_q    <= 1'b1;
    end else begin
      start_q <= cnv_start_n;
      cs_q    <= cs_n;
    end
  end

  assign start_fall = start_q & ~cnv_start_n;
  assign cs_fall    = cs_q & ~cs_n;

  always_comb begin
    if (mode_uses_pin(mode)) trig = start_fall;
    else                     trig = conv_cmd;
  end

endmodule

// File: rtl/ctl_avg_accum.sv
module ctl_avg_accum #(
  parameter int DATA_W      = 12,
  parameter int MAX_AVG_LOG = 5,
  localparam int ACC_W      = DATA_W + MAX_AVG_LOG,
  localparam int SH_W       = $clog2(MAX_AVG_LOG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   shift,
  output logic [DATA_W-1:0] dout
);

  logic [ACC_W-1:0] sum_q;
  logic [ACC_W-1:0] shifted;

  always_ff @(posedge clk) begin
    if (!rst_n)   sum_q <= '0;
    else if (clr) sum_q <= '0;
    else if (add) sum_q <= sum_q + ACC_W'(din);
  end

  assign shifted = sum_q >> shift;
  assign dout    = shifted[DATA_W-1:0];

endmodule

// File: rtl/ctl_seq_fsm.sv
module ctl_seq_fsm
  import conv_trig_pkg::*;
#(
  parameter int CH_W        = 4,
  parameter int MAX_AVG_LOG = 5,
  localparam int SH_W       = $clog2(MAX_AVG_LOG + 1),
  localparam int CNT_W      = MAX_AVG_LOG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  trig_mode_e      mode,
  input  logic [CH_W-1:0] last_chan,
  input  logic            avg_en,
  input  logic [1:0]      avg_sel,
  input  logic            adc_done,
  input  logic            res_ready,
  output logic            adc_start,
  output logic [CH_W-1:0] adc_chan,
  output logic            res_valid,
  output logic            acc_clr,
  output logic            acc_add,
  output logic [SH_W-1:0] shift,
  output logic            seq_done
);

  seq_state_e      state_q;
  logic [CH_W-1:0] chan_q;
  logic [CH_W-1:0] last_q;
  logic            scan_q;
  logic [SH_W-1:0] shift_q;
  logic [CNT_W-1:0] samp_q;
  logic [CNT_W-1:0] samp_max;
  logic            accept;
  logic            final_chan;
  logic            take;

  assign take       = (state_q == S_IDLE) && trig;
  assign accept     = (state_q == S_OUT) && res_ready;
  assign final_chan = !scan_q || (chan_q == last_q);
  assign samp_max   = CNT_W'((1 << shift_q) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      chan_q  <= '0;
      last_q  <= '0;
      scan_q  <= 1'b0;
      shift_q <= '0;
      samp_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (trig) begin
            scan_q  <= mode_scans(mode);
            last_q  <= last_chan;
            chan_q  <= mode_scans(mode) ? '0 : last_chan;
            shift_q <= (avg_en && (mode != MD_EXT_SINGLE))
                       ? SH_W'(avg_sel) + SH_W'(2) : '0;
            samp_q  <= '0;
            state_q <= S_LAUNCH;
          end
        end
        S_LAUNCH: state_q <= S_WAIT;
        S_WAIT: begin
          if (adc_done) begin
            if (samp_q == samp_max) begin
              state_q <= S_OUT;
            end else begin
              samp_q  <= samp_q + 1'b1;
              state_q <= S_LAUNCH;
            end
          end
        end
        S_OUT: begin
          if (res_ready) begin
            samp_q <= '0;
            if (final_chan) begin
              state_q <= S_IDLE;
            end else begin
              chan_q  <= chan_q + 1'b1;
              state_q <= S_LAUNCH;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign adc_start = (state_q == S_LAUNCH);
  assign adc_chan  = chan_q;
  assign res_valid = (state_q == S_OUT);
  assign acc_clr   = take || accept;
  assign acc_add   = (state_q == S_WAIT) && adc_done;
  assign shift     = shift_q;
  assign seq_done  = accept && final_chan;

endmodule

// File: rtl/ctl_eoc_gen.sv
module ctl_eoc_gen
  import conv_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       seq_done,
  input  logic       start_fall,
  input  logic       cs_fall,
  output logic       eoc_n
);

  always_ff @(posedge clk) begin
    if (!rst_n)                        eoc_n <= 1'b1;
    else if (mode == MD_EXT_SINGLE)    eoc_n <= 1'b1;
    else if (start_fall || cs_fall)    eoc_n <= 1'b1;
    else if (seq_done)                 eoc_n <= 1'b0;
  end

endmodule

// File: rtl/conv_trigger_ctrl.sv
module conv_trigger_ctrl
  import conv_trig_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int DATA_W      = 12,
  parameter int MAX_AVG_LOG = 5,
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int SH_W       = $clog2(MAX_AVG_LOG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              cnv_start_n,
  input  logic              conv_cmd,
  input  logic              cs_n,
  input  logic [CH_W-1:0]   last_chan,
  input  logic              avg_en,
  input  logic [1:0]        avg_sel,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_start,
  output logic [CH_W-1:0]   adc_chan,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_chan,
  output logic              eoc_n
);

  trig_mode_e      mode;
  logic            trig;
  logic            start_fall;
  logic            cs_fall;
  logic            acc_clr;
  logic            acc_add;
  logic [SH_W-1:0] shift;
  logic            seq_done;

  assign mode = trig_mode_e'(mode_sel);

  ctl_trig_detect u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .cnv_start_n(cnv_start_n),
    .cs_n       (cs_n),
    .conv_cmd   (conv_cmd),
    .trig       (trig),
    .start_fall (start_fall),
    .cs_fall    (cs_fall)
  );

  ctl_seq_fsm #(
    .CH_W       (CH_W),
    .MAX_AVG_LOG(MAX_AVG_LOG)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig),
    .mode     (mode),
    .last_chan(last_chan),
    .avg_en   (avg_en),
    .avg_sel  (avg_sel),
    .adc_done (adc_done),
    .res_ready(res_ready),
    .adc_start(adc_start),
    .adc_chan (adc_chan),
    .res_valid(res_valid),
    .acc_clr  (acc_clr),
    .acc_add  (acc_add),
    .shift    (shift),
    .seq_done (seq_done)
  );

  ctl_avg_accum #(
    .DATA_W     (DATA_W),
    .MAX_AVG_LOG(MAX_AVG_LOG)
  ) u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (acc_clr),
    .add  (acc_add),
    .din  (adc_data),
    .shift(shift),
    .dout (res_data)
  );

  ctl_eoc_gen u_eoc (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .seq_done  (seq_done),
    .start_fall(start_fall),
    .cs_fall   (cs_fall),
    .eoc_n     (eoc_n)
  );

  assign res_chan = adc_chan;

endmodule

// File: rtl/conv_trigger_ctrl_chk.sv
module conv_trigger_ctrl_chk #(
  parameter int DATA_W = 12,
  parameter int CH_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_sel,
  input logic              cnv_start_n,
  input logic              cs_n,
  input logic              adc_start,
  input logic [CH_W-1:0]   adc_chan,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic [CH_W-1:0]   res_chan,
  input logic              eoc_n
);

  // R5: externally timed mode keeps the flag high
  a_r5_eoc_high_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |=> eoc_n);

  // R7: chip select falling edge raises the flag
  a_r7_cs_raises_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> eoc_n);

  // R7: start pin falling edge raises the flag
  a_r7_pin_raises_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_start_n) |=> eoc_n);

  // R2: the flag only falls right after a result was accepted
  a_r2_eoc_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_n) |-> $past(res_valid && res_ready));

  // R9: a stalled result holds still
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan)));

  // R9: no sample is requested while a result waits
  a_r9_no_start_while_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !adc_start);

  // R10: start request is a single-cycle pulse with a steady channel
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> (!adc_start && $stable(adc_chan)));

endmodule

bind conv_trigger_ctrl conv_trigger_ctrl_chk #(
  .DATA_W(DATA_W),
  .CH_W  (CH_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel   (mode_sel),
  .cnv_start_n(cnv_start_n),
  .cs_n       (cs_n),
  .adc_start  (adc_start),
  .adc_chan   (adc_chan),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_data   (res_data),
  .res_chan   (res_chan),
  .eoc_n      (eoc_n)
);

// File: tb/conv_trigger_ctrl_tb_top.sv
module conv_trigger_ctrl_tb_top;

  localparam int NUM_CH = 16;
  localparam int DATA_W = 12;
  localparam int CH_W   = 4;
  localparam int LAT    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode_sel = 2'b10;
  logic              cnv_start_n = 1'b1;
  logic              conv_cmd = 1'b0;
  logic              cs_n = 1'b1;
  logic [CH_W-1:0]   last_chan = '0;
  logic              avg_en = 1'b0;
  logic [1:0]        avg_sel = 2'b00;
  logic              adc_done;
  logic [DATA_W-1:0] adc_data;
  logic              adc_start;
  logic [CH_W-1:0]   adc_chan;
  logic              res_valid;
  logic              res_ready = 1'b0;
  logic [DATA_W-1:0] res_data;
  logic [CH_W-1:0]   res_chan;
  logic              eoc_n;

  int checks = 0;
  int errors = 0;
  int kbase  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  conv_trigger_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cnv_start_n(cnv_start_n),
    .conv_cmd(conv_cmd), .cs_n(cs_n), .last_chan(last_chan), .avg_en(avg_en),
    .avg_sel(avg_sel), .adc_done(adc_done), .adc_data(adc_data),
    .adc_start(adc_start), .adc_chan(adc_chan), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_chan(res_chan), .eoc_n(eoc_n)
  );

  function automatic int hsh(int c, int k);
    return (c * 311 + k * 1237 + 5) % 4096;
  endfunction

  function automatic int exp_avg(int c, int k0, int n, int lg);
    int s = 0;
    for (int j = 0; j < n; j++) s += hsh(c, k0 + j);
    return s >> lg;
  endfunction

  // converter model with fixed latency
  int          stub_k;
  int          stub_cnt;
  logic [CH_W-1:0] stub_ch;
  always @(posedge clk) begin
    adc_done <= 1'b0;
    if (!rst_n) begin
      stub_k   <= 0;
      stub_cnt <= 0;
      stub_ch  <= '0;
      adc_data <= '0;
    end else if (adc_start) begin
      stub_cnt <= LAT;
      stub_ch  <= adc_chan;
    end else if (stub_cnt > 0) begin
      stub_cnt <= stub_cnt - 1;
      if (stub_cnt == 1) begin
        adc_done <= 1'b1;
        adc_data <= DATA_W'(hsh(int'(stub_ch), stub_k));
        stub_k   <= stub_k + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_cs();
    cs_n = 1'b0; tick(1); cs_n = 1'b1; tick(1);
  endtask

  task automatic pulse_pin();
    cnv_start_n = 1'b0; tick(1); cnv_start_n = 1'b1; tick(1);
  endtask

  task automatic trigger(input logic [1:0] m);
    if (!m[1]) begin
      pulse_pin();
    end else begin
      cs_n = 1'b0; conv_cmd = 1'b1; tick(1);
      conv_cmd = 1'b0; cs_n = 1'b1; tick(1);
    end
  endtask

  task automatic run_seq(input logic [1:0] m, input int last, input bit aen,
                         input int asel, input bit busy_poke, input string req);
    int nres  = (m == 2'b00 || m == 2'b10) ? last + 1 : 1;
    int first = (m == 2'b00 || m == 2'b10) ? 0 : last;
    int lg    = (aen && m != 2'b11) ? 2 + asel : 0;
    int n     = 1 << lg;
    tick(1);
    mode_sel = m; last_chan = CH_W'(last); avg_en = aen; avg_sel = 2'(asel);
    tick(1);
    trigger(m);
    chk(eoc_n === 1'b1, {req, " R7 eoc high after trigger"}, int'(eoc_n), 1);
    if (busy_poke) begin
      // R8: a second trigger and new settings mid-run change nothing
      last_chan = CH_W'(last + 3);
      avg_sel   = 2'(asel + 1);
      trigger(m);
    end
    for (int i = 0; i < nres; i++) begin
      int wait_n = 0;
      int hold;
      int ksave;
      while (!res_valid && wait_n < 8000) begin tick(1); wait_n++; end
      chk(res_valid === 1'b1, {req, " result appears"}, int'(res_valid), 1);
      hold = int'($urandom_range(0, 3));
      ksave = stub_k;
      tick(hold);
      chk(res_valid === 1'b1 && stub_k == ksave, {req, " R9 stall holds"}, stub_k, ksave);
      chk(int'(res_chan) == first + i, {req, " R2 channel order"}, int'(res_chan), first + i);
      chk(int'(res_data) == exp_avg(first + i, kbase, n, lg), {req, " R6 result value"},
          int'(res_data), exp_avg(first + i, kbase, n, lg));
      chk(eoc_n === 1'b1, {req, " R2 eoc high before last accept"}, int'(eoc_n), 1);
      kbase += n;
      res_ready = 1'b1; tick(1); res_ready = 1'b0;
    end
    tick(1);
    chk(eoc_n === ((m == 2'b11) ? 1'b1 : 1'b0), {req, " R3 eoc after completion"},
        int'(eoc_n), (m == 2'b11) ? 1 : 0);
    tick(20);
    chk(res_valid === 1'b0 && stub_k == kbase, {req, " R8 no extra conversions"}, stub_k, kbase);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    tick(3);
    chk(eoc_n === 1'b1 && res_valid === 1'b0 && adc_start === 1'b0, "R1 reset state",
        int'({eoc_n, res_valid, adc_start}), 4);
    rst_n = 1'b1;
    tick(2);
    chk(eoc_n === 1'b1 && res_valid === 1'b0, "R1 after reset release", int'(eoc_n), 1);

    run_seq(2'b10, 3, 1'b0, 0, 1'b0, "R4 cmd scan");
    // R4: start pin only raises the flag in command mode
    pulse_pin();
    chk(eoc_n === 1'b1, "R7 pin raises eoc", int'(eoc_n), 1);
    tick(20);
    chk(stub_k == kbase && res_valid === 1'b0, "R4 pin does not trigger", stub_k, kbase);

    run_seq(2'b00, 2, 1'b1, 0, 1'b1, "R2 pin scan busy");
    pulse_cs();
    chk(eoc_n === 1'b1, "R7 cs raises eoc", int'(eoc_n), 1);

    run_seq(2'b01, 5, 1'b1, 3, 1'b0, "R3 pin single avg32");
    run_seq(2'b01, 7, 1'b0, 0, 1'b0, "R3 pin single again");
    run_seq(2'b11, 9, 1'b1, 3, 1'b0, "R5 ext single no avg");
    tick(5);
    chk(eoc_n === 1'b1, "R5 eoc high in mode 11", int'(eoc_n), 1);
    run_seq(2'b10, 15, 1'b1, 1, 1'b0, "R6 full scan avg8");

    for (int it = 0; it < 8; it++) begin
      logic [1:0] m = 2'($urandom_range(0, 3));
      run_seq(m, int'($urandom_range(0, 5)), 1'($urandom_range(0, 1)),
              int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule